// File: doc/BRIEF.md
# Banked Register SPI Command Slave

This block is an SPI mode-0 slave that runs a small header-plus-data command set against a local model: four banks of thirty-two 8-bit control registers and a byte-addressed buffer memory. The first byte of every chip-select frame is a header. Its top three bits pick the operation and its low five bits pick a register. The following bytes carry write data, bit masks or buffer contents. Read data comes back on MISO, most significant bit first.

Two bits of a register shared by all banks select the active bank, and that bank redirects every banked address. Registers in the upper two banks below the shared window form a slow class: a read of one of them returns a dummy byte before the data. Two pointers run the buffer traffic, one for reads and one for writes. Both are visible as registers in bank 0.

The serial pins are sampled by the system clock through synchronisers. A frame walks through the states IDLE, HDR, ARG, DUMMY, RDDAT, BUFRD, BUFWR, DONE and DROP:
- Any synchronised chip-select high forces IDLE.
- IDLE→HDR happens once chip select is low.
- When the header completes, HDR moves to RDDAT (ordinary read), DUMMY (slow-class read), ARG (write, bit set, bit clear), BUFRD, BUFWR, DONE (reset command) or DROP (unknown opcode or malformed buffer header).
- ARG→DONE and RDDAT→DONE happen on the next complete byte.
- DUMMY→RDDAT happens on the next complete byte.
- BUFRD and BUFWR stay in place, moving one byte per complete byte.
- DONE and DROP hold until chip select rises.

Top module: `spi_bank_slave`

## Requirements
- R1: Header bits 7:5 are the opcode and bits 4:0 the register address; for an ordinary read (opcode 000) the register value is shifted out on MISO during the second byte, MSB first, changing after SCK falls and valid at the following rise.
- R2: The active bank is bits 1:0 of the register at address 0x1F (bit 1 the upper bank bit) and is shown on `bank_dbg`; addresses 0x1B–0x1F name the same storage in every bank, lower addresses name separate storage per bank.
- R3: Opcode 010 stores the second byte in the addressed register of the active bank.
- R4: Opcode 100 ORs the second byte into the register; opcode 101 clears every register bit whose mask bit is 1.
- R5: A read (opcode 000) of an address below 0x1B while the bank is 2 or 3 returns 0x00 during the second byte and the register value during the third.
- R6: Header 0x3A starts a buffer read: each following byte returns the buffer byte at the read pointer, which advances after every complete byte and wraps at 2**BUF_AW.
- R7: Header 0x7A starts a buffer write: each following complete MOSI byte is stored at the write pointer, which then advances and wraps at 2**BUF_AW.
- R8: In bank 0, address 0x00 is the read pointer and address 0x01 the write pointer; writes and bit operations load them, and reads return their current value, zero-extended.
- R9: Opcode 111 (a one-byte frame) clears bits 1:0 of register 0x1F and leaves its bits 7:2 unchanged.
- R10: Raising CS_n before the eighth bit of a byte discards that byte: no register, pointer or buffer changes.
- R11: Frames with opcode 110, or with opcode 001/011 and any header other than 0x3A/0x7A, change nothing and keep MISO at 0 throughout.
- R12: After reset every register, both pointers and the buffer hold 0, the bank is 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| cs_n | input | 1 | Active-low chip select, frames a command |
| mosi | input | 1 | Serial data in, sampled on SCK rise |
| miso | output | 1 | Serial data out, updated after SCK fall, 0 when idle |
| bank_dbg | output | 2 | Currently selected register bank |

## Verification
The bench uses the default BUF_AW of 4, so the buffer is only 16 bytes deep. Short bursts placed near the top of the buffer therefore carry both pointers across the wrap point. SYNC_STAGES stays at 2, and the bench holds each SCK phase for six system clocks so that a MISO change after a synchronised fall is settled before the next rise. Random register writes to address 0x1F move the bank through all four values, which brings the slow-class dummy-byte path and the shared window into the random mix.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;

    localparam int BANK_COUNT    = 4;
    localparam int REGS_PER_BANK = 32;
    localparam int REG_COUNT     = BANK_COUNT * REGS_PER_BANK;

    localparam logic [4:0] BANK_REG_ADDR = 5'h1F;
    localparam logic [4:0] SHARED_BASE   = 5'h1B;

    localparam logic [2:0] OPC_READ   = 3'b000;
    localparam logic [2:0] OPC_BUF_RD = 3'b001;
    localparam logic [2:0] OPC_WRITE  = 3'b010;
    localparam logic [2:0] OPC_BUF_WR = 3'b011;
    localparam logic [2:0] OPC_SET    = 3'b100;
    localparam logic [2:0] OPC_CLR    = 3'b101;
    localparam logic [2:0] OPC_RESET  = 3'b111;

    localparam logic [7:0] HDR_BUF_RD = 8'h3A;
    localparam logic [7:0] HDR_BUF_WR = 8'h7A;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR, ST_ARG, ST_DUMMY, ST_RDDAT,
        ST_BUFRD, ST_BUFWR, ST_DONE, ST_DROP
    } frame_state_t;

    typedef enum logic [1:0] {
        WOP_LOAD, WOP_SET, WOP_CLR
    } wr_op_t;

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_n_s,
    output logic mosi_s
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0]   sck_q;
    logic [SYNC_STAGES-1:0] cs_q;
    logic [SYNC_STAGES-1:0] mosi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[SYNC_STAGES-1:0], sck_i};
            cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n_i};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi_i};
        end
    end

    assign sck_rise = sck_q[LAST] & ~sck_q[SYNC_STAGES];
    assign sck_fall = ~sck_q[LAST] & sck_q[SYNC_STAGES];
    assign cs_n_s   = cs_q[LAST];
    assign mosi_s   = mosi_q[LAST];
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import spi_bank_pkg::*;
#(
    parameter int BUF_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_slow,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  wr_op_t            wr_op,
    input  logic [7:0]        wr_data,
    input  logic              bank_clr,
    input  logic              rd_inc,
    input  logic              wr_inc,
    output logic [1:0]        bank,
    output logic [BUF_AW-1:0] rd_ptr,
    output logic [BUF_AW-1:0] wr_ptr
);
    localparam int IDX_W = $clog2(REG_COUNT);
    localparam int BANK_IDX = int'(BANK_REG_ADDR);
    localparam logic [IDX_W-1:0] RDPTR_IDX = IDX_W'(0);
    localparam logic [IDX_W-1:0] WRPTR_IDX = IDX_W'(1);

    logic [7:0]        regs_q [REG_COUNT];
    logic [BUF_AW-1:0] rd_ptr_q, wr_ptr_q;
    logic [IDX_W-1:0]  ridx, widx;
    logic [7:0]        old_val, new_val;

    function automatic logic [IDX_W-1:0] map_idx(input logic [4:0] a, input logic [1:0] b);
        if (a >= SHARED_BASE) return IDX_W'(a);
        return IDX_W'({b, a});
    endfunction

    assign bank    = regs_q[BANK_IDX][1:0];
    assign ridx    = map_idx(rd_addr, bank);
    assign widx    = map_idx(wr_addr, bank);
    assign rd_slow = bank[1] && (rd_addr < SHARED_BASE);

    always_comb begin
        rd_data = regs_q[ridx];
        if (ridx == RDPTR_IDX) rd_data = 8'(rd_ptr_q);
        if (ridx == WRPTR_IDX) rd_data = 8'(wr_ptr_q);
        old_val = regs_q[widx];
        if (widx == RDPTR_IDX) old_val = 8'(rd_ptr_q);
        if (widx == WRPTR_IDX) old_val = 8'(wr_ptr_q);
    end

    always_comb begin
        unique case (wr_op)
            WOP_LOAD: new_val = wr_data;
            WOP_SET:  new_val = old_val | wr_data;
            WOP_CLR:  new_val = old_val & ~wr_data;
            default:  new_val = old_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= '0;
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
        end else begin
            if (wr_en) regs_q[widx] <= new_val;
            if (bank_clr) regs_q[BANK_IDX][1:0] <= 2'b00;
            if (wr_en && widx == RDPTR_IDX) rd_ptr_q <= new_val[BUF_AW-1:0];
            else if (rd_inc)                rd_ptr_q <= rd_ptr_q + BUF_AW'(1);
            if (wr_en && widx == WRPTR_IDX) wr_ptr_q <= new_val[BUF_AW-1:0];
            else if (wr_inc)                wr_ptr_q <= wr_ptr_q + BUF_AW'(1);
        end
    end

    assign rd_ptr = rd_ptr_q;
    assign wr_ptr = wr_ptr_q;

    assert_bank_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_clr |=> (bank == 2'b00));
    assert_rdptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_inc && !wr_en) |=> (rd_ptr_q == $past(rd_ptr_q) + BUF_AW'(1)));
    assert_wrptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inc && !wr_en) |=> (wr_ptr_q == $past(wr_ptr_q) + BUF_AW'(1)));
endmodule

// File: rtl/byte_buffer.sv
module byte_buffer #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/spi_bank_slave.sv
module spi_bank_slave
    import spi_bank_pkg::*;
#(
    parameter int BUF_AW      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       miso,
    output logic [1:0] bank_dbg
);
    logic sck_rise, sck_fall, cs_n_s, mosi_s;

    frame_state_t      state_q, state_nxt;
    logic [2:0]        bit_cnt_q;
    logic [6:0]        shift_q;
    logic [7:0]        byte_val;
    logic              byte_done;
    logic [4:0]        hdr_addr_q;
    wr_op_t            hdr_op_q;
    logic [7:0]        tx_q;
    logic              miso_q;

    logic              tx_load;
    logic [7:0]        tx_val;
    logic              rf_wr_en, rf_bank_clr, rf_rd_inc, rf_wr_inc, buf_we;
    logic [4:0]        rf_rd_addr;
    logic [7:0]        rf_rd_data, buf_rdata;
    logic              rf_slow;
    logic [1:0]        bank;
    logic [BUF_AW-1:0] rd_ptr, wr_ptr, buf_raddr;

    spi_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_n_s(cs_n_s), .mosi_s(mosi_s)
    );

    bank_regfile #(.BUF_AW(BUF_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_addr(rf_rd_addr), .rd_data(rf_rd_data),
        .rd_slow(rf_slow), .wr_en(rf_wr_en), .wr_addr(hdr_addr_q), .wr_op(hdr_op_q),
        .wr_data(byte_val), .bank_clr(rf_bank_clr), .rd_inc(rf_rd_inc),
        .wr_inc(rf_wr_inc), .bank(bank), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
    );

    byte_buffer #(.AW(BUF_AW)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .waddr(wr_ptr), .wdata(byte_val),
        .raddr(buf_raddr), .rdata(buf_rdata)
    );

    assign byte_val   = {shift_q, mosi_s};
    assign byte_done  = sck_rise && (bit_cnt_q == 3'd7);
    assign rf_rd_addr = (state_q == ST_HDR) ? byte_val[4:0] : hdr_addr_q;
    assign buf_raddr  = (state_q == ST_BUFRD) ? rd_ptr + BUF_AW'(1) : rd_ptr;

    always_comb begin
        state_nxt   = state_q;
        tx_load     = 1'b0;
        tx_val      = 8'h00;
        rf_wr_en    = 1'b0;
        rf_bank_clr = 1'b0;
        rf_rd_inc   = 1'b0;
        rf_wr_inc   = 1'b0;
        buf_we      = 1'b0;
        if (cs_n_s) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_nxt = ST_HDR;
                ST_HDR: if (byte_done) begin
                    unique case (byte_val[7:5])
                        OPC_READ: begin
                            tx_load = 1'b1;
                            tx_val  = rf_slow ? 8'h00 : rf_rd_data;
                            state_nxt = rf_slow ? ST_DUMMY : ST_RDDAT;
                        end
                        OPC_BUF_RD: begin
                            tx_load = (byte_val == HDR_BUF_RD);
                            tx_val  = buf_rdata;
                            state_nxt = (byte_val == HDR_BUF_RD) ? ST_BUFRD : ST_DROP;
                        end
                        OPC_BUF_WR: state_nxt = (byte_val == HDR_BUF_WR) ? ST_BUFWR : ST_DROP;
                        OPC_WRITE, OPC_SET, OPC_CLR: state_nxt = ST_ARG;
                        OPC_RESET: begin
                            rf_bank_clr = 1'b1;
                            state_nxt   = ST_DONE;
                        end
                        default: state_nxt = ST_DROP;
                    endcase
                end
                ST_ARG: if (byte_done) begin
                    rf_wr_en  = 1'b1;
                    state_nxt = ST_DONE;
                end
                ST_DUMMY: if (byte_done) begin
                    tx_load   = 1'b1;
                    tx_val    = rf_rd_data;
                    state_nxt = ST_RDDAT;
                end
                ST_RDDAT: if (byte_done) begin
                    tx_load   = 1'b1;
                    state_nxt = ST_DONE;
                end
                ST_BUFRD: if (byte_done) begin
                    rf_rd_inc = 1'b1;
                    tx_load   = 1'b1;
                    tx_val    = buf_rdata;
                end
                ST_BUFWR: if (byte_done) begin
                    buf_we    = 1'b1;
                    rf_wr_inc = 1'b1;
                end
                ST_DONE, ST_DROP: state_nxt = state_q;
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shift_q    <= '0;
            hdr_addr_q <= '0;
            hdr_op_q   <= WOP_LOAD;
            tx_q       <= '0;
            miso_q     <= 1'b0;
        end else if (cs_n_s) begin
            bit_cnt_q <= '0;
            tx_q      <= '0;
            miso_q    <= 1'b0;
        end else begin
            if (sck_rise) begin
                bit_cnt_q <= bit_cnt_q + 3'd1;
                shift_q   <= byte_val[6:0];
            end
            if (state_q == ST_HDR && byte_done) begin
                hdr_addr_q <= byte_val[4:0];
                unique case (byte_val[7:5])
                    OPC_SET: hdr_op_q <= WOP_SET;
                    OPC_CLR: hdr_op_q <= WOP_CLR;
                    default: hdr_op_q <= WOP_LOAD;
                endcase
            end
            if (sck_fall) begin
                miso_q <= tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b0};
            end
            if (tx_load) tx_q <= tx_val;
        end
    end

    assign miso     = miso_q;
    assign bank_dbg = bank;

    assert_drop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |-> !miso_q);
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (state_q == ST_IDLE));
    assert_dummy_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DUMMY) |-> bank[1]);
    assert_idle_miso_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (!miso_q || !cs_n_s));
endmodule

// File: tb/sim_spi_bank_slave.sv
`timescale 1ns/1ps
module sim_spi_bank_slave;
    localparam int HALF = 6;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic [1:0] bank_dbg;

    always #2.5 clk = ~clk;

    spi_bank_slave #(.BUF_AW(AW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .bank_dbg(bank_dbg)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] tx_b [16];
    logic [7:0] rx_b [16];
    logic [7:0] m_reg [128];
    logic [7:0] m_buf [DEPTH];
    int m_rp = 0;
    int m_wp = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int m_bank();
        return int'(m_reg[31][1:0]);
    endfunction

    function automatic int m_idx(input int a);
        if (a >= 27) return a;
        return m_bank() * 32 + a;
    endfunction

    function automatic logic [7:0] m_read(input int a);
        int i = m_idx(a);
        if (i == 0) return 8'(m_rp);
        if (i == 1) return 8'(m_wp);
        return m_reg[i];
    endfunction

    function automatic bit m_slow(input int a);
        return (m_bank() >= 2) && (a < 27);
    endfunction

    task automatic m_write(input int op, input int a, input logic [7:0] d);
        int i = m_idx(a);
        logic [7:0] old = m_read(a);
        logic [7:0] nv = (op == 0) ? d : (op == 1) ? (old | d) : (old & ~d);
        m_reg[i] = nv;
        if (i == 0) m_rp = int'(nv) % DEPTH;
        if (i == 1) m_wp = int'(nv) % DEPTH;
    endtask

    task automatic xfer(input int n, input int part_bits);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            logic [7:0] r = '0;
            for (int b = 7; b >= 0; b--) begin
                if (i == n - 1 && part_bits > 0 && (7 - b) >= part_bits) break;
                mosi = tx_b[i][b];
                repeat (HALF) @(negedge clk);
                r[b] = miso;
                sck = 1'b1;
                repeat (HALF) @(negedge clk);
                sck = 1'b0;
            end
            rx_b[i] = r;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic do_read(input int a, input string req);
        logic [7:0] exp = m_read(a);
        bit slow = m_slow(a);
        tx_b[0] = {3'b000, 5'(a)};
        tx_b[1] = 8'h00;
        tx_b[2] = 8'h00;
        xfer(slow ? 3 : 2, 0);
        if (slow) begin
            chk(rx_b[1] == 8'h00, "R5 dummy byte", rx_b[1], 0);
            chk(rx_b[2] == exp, req, rx_b[2], exp);
        end else begin
            chk(rx_b[1] == exp, req, rx_b[1], exp);
        end
    endtask

    task automatic do_wreg(input int op, input int a, input logic [7:0] d);
        logic [2:0] opc = (op == 0) ? 3'b010 : (op == 1) ? 3'b100 : 3'b101;
        tx_b[0] = {opc, 5'(a)};
        tx_b[1] = d;
        xfer(2, 0);
        m_write(op, a, d);
    endtask

    task automatic do_bufwr(input int n);
        tx_b[0] = 8'h7A;
        for (int i = 1; i <= n; i++) tx_b[i] = 8'($urandom);
        xfer(n + 1, 0);
        for (int i = 1; i <= n; i++) begin
            m_buf[m_wp] = tx_b[i];
            m_wp = (m_wp + 1) % DEPTH;
        end
    endtask

    task automatic do_bufrd(input int n);
        tx_b[0] = 8'h3A;
        for (int i = 1; i <= n; i++) tx_b[i] = 8'($urandom);
        xfer(n + 1, 0);
        for (int i = 1; i <= n; i++) begin
            chk(rx_b[i] == m_buf[m_rp], "R6 buffer read", rx_b[i], m_buf[m_rp]);
            m_rp = (m_rp + 1) % DEPTH;
        end
    endtask

    task automatic do_reset_cmd();
        tx_b[0] = {3'b111, 5'($urandom)};
        xfer(1, 0);
        m_reg[31][1:0] = 2'b00;
    endtask

    task automatic do_bad(input int kind);
        logic [4:0] a = 5'($urandom);
        if (kind != 0 && a == 5'h1A) a = 5'h1B;
        tx_b[0] = (kind == 0) ? {3'b110, a} : (kind == 1) ? {3'b001, a} : {3'b011, a};
        tx_b[1] = 8'($urandom);
        tx_b[2] = 8'($urandom);
        xfer(3, 0);
        chk(rx_b[0] == 0 && rx_b[1] == 0 && rx_b[2] == 0, "R11 ignored frame miso",
            {rx_b[0], rx_b[1], rx_b[2]}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 128; i++) m_reg[i] = '0;
        for (int i = 0; i < DEPTH; i++) m_buf[i] = '0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        chk(miso == 1'b0, "R12 miso after reset", miso, 0);
        chk(bank_dbg == 2'b00, "R12 bank after reset", bank_dbg, 0);
        do_read(5, "R12 register zero after reset");
        do_bufrd(2);

        do_wreg(0, 5'h08, 8'h3C);
        do_read(5'h08, "R3 write then read");
        do_read(5'h08, "R1 ordinary read on second byte");

        do_wreg(0, 5'h1F, 8'h02);
        chk(bank_dbg == 2'b10, "R2 bank from reg 0x1F", bank_dbg, 2);
        do_wreg(0, 5'h03, 8'hA5);
        do_read(5'h03, "R5 slow register data on third byte");
        do_wreg(0, 5'h1F, 8'h01);
        chk(bank_dbg == 2'b01, "R2 bank 1 selected", bank_dbg, 1);
        do_read(5'h03, "R2 separate banked storage");
        do_wreg(0, 5'h1C, 8'h77);
        do_wreg(0, 5'h1F, 8'h03);
        do_read(5'h1C, "R2 shared window same in every bank");

        do_wreg(0, 5'h1F, 8'h01);
        do_wreg(0, 5'h04, 8'h81);
        do_wreg(1, 5'h04, 8'h18);
        do_read(5'h04, "R4 bit set");
        do_wreg(2, 5'h04, 8'h09);
        do_read(5'h04, "R4 bit clear");

        do_wreg(0, 5'h1F, 8'hF3);
        do_reset_cmd();
        chk(bank_dbg == 2'b00, "R9 bank cleared by reset command", bank_dbg, 0);
        do_read(5'h1F, "R9 upper bits of 0x1F kept");

        do_wreg(0, 5'h05, 8'h11);
        tx_b[0] = 8'h45;
        tx_b[1] = 8'hFF;
        xfer(2, 7);
        do_read(5'h05, "R10 aborted write has no effect");

        do_wreg(0, 5'h01, 8'd14);
        do_bufwr(4);
        do_read(5'h01, "R8 write pointer wrapped");
        do_wreg(0, 5'h00, 8'd14);
        do_read(5'h00, "R8 read pointer loaded");
        do_bufrd(4);
        do_read(5'h00, "R6 read pointer wrapped");

        tx_b[0] = 8'h3A;
        tx_b[1] = 8'h00;
        xfer(2, 5);
        do_read(5'h00, "R10 aborted buffer byte keeps pointer");

        do_bad(0);
        do_bad(1);
        do_bad(2);
        do_read(5'h00, "R11 bad buffer header keeps read pointer");
        do_read(5'h01, "R11 bad buffer header keeps write pointer");
        do_bufrd(3);

        for (int k = 0; k < 150; k++) begin
            int sel = $urandom_range(0, 9);
            int a = $urandom_range(0, 31);
            case (sel)
                0, 1: do_read(a, "R1 random read");
                2: do_wreg(0, a, 8'($urandom));
                3: do_wreg(1, a, 8'($urandom));
                4: do_wreg(2, a, 8'($urandom));
                5: do_bufwr($urandom_range(1, 5));
                6: do_bufrd($urandom_range(1, 5));
                7: do_reset_cmd();
                8: do_bad($urandom_range(0, 2));
                default: do_read(5'h1F, "R3 random bank register read");
            endcase
            chk(bank_dbg == m_reg[31][1:0], "R2 bank tracks reg 0x1F", bank_dbg, m_reg[31][1:0]);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule